// File: doc/BRIEF.md
# DMA Register Command Decoder

This block sits between a CPU bus port and the register file of a multi-channel DMA controller. It watches chip select, read and write strobes and a 4-bit register address. Some addresses are commands: the access itself is the whole message and the data bus plays no part. The block holds three pieces of state. The first is the byte-order pointer that tells the channel register file whether the current access to an address or word-count register hits the low or the high byte. The second is a readback pointer that walks the per-channel mode registers behind one shared read address. The third is the per-channel request mask.

A master-clear write returns the block's own state to its reset values. It also emits a one-cycle pulse that the transfer engine and the arbiter OR into their hardware reset. Mode register contents live in the channel logic and arrive on a flat input bus. The block only selects one of them and formats it for the read bus.

Each access is one clock cycle with exactly one strobe high. Commands take effect at the end of that cycle. Read data is combinational during the access cycle.

Top module: `dma_cmd_ctrl`

## Requirements
- R1: After hardware reset, every mask bit is 1, `byte_hi` is 0 (low byte next), the mode readback pointer selects channel 0, `mclr_pulse` is 0 and `rdata` is 0.
- R2: A cycle with `cs` low, with neither strobe high, or with both `rd` and `wr` high changes no state. This covers the mask, the byte pointer and the mode pointer.
- R3: Any read or write to an address in the range 0x0–0x7 (channel address and word-count registers) inverts `byte_hi` at the end of that access. During the access, `byte_hi` tells which byte it hits (0 = low, 1 = high).
- R4: A write to 0xC forces `byte_hi` to 0, and a read of 0xC forces it to 1, whatever the data bus holds.
- R5: A write to 0xE clears all mask bits, whatever the data bus holds.
- R6: A write to 0xF loads the mask from `wdata[3:0]`, with bit n belonging to channel n.
- R7: A write to 0xA changes one mask bit. `wdata[1:0]` names the channel and `wdata[2]` is the new value (1 = masked). The other bits are kept.
- R8: A read of 0xF returns `{mode[p], 2'b11}`, where p is the readback pointer and channel n's mode occupies `mode_bits[6n+5:6n]`. The pointer then advances by one and wraps from channel 3 to channel 0.
- R9: A read of 0xD returns the mode readback pointer to channel 0.
- R10: A write to 0xD (master clear) sets every mask bit, clears `byte_hi` and returns the mode pointer to channel 0 at the end of that cycle. `mclr_pulse` is high for exactly the following cycle.
- R11: `rdata` is 0 in every cycle except a read of 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| mode_bits | input | 24 | Mode register contents of all channels, channel n at bits [6n+5:6n] |
| rdata | output | 8 | Read data for mode readback, else 0 |
| byte_hi | output | 1 | Byte pointer: 1 when the current address/count access hits the high byte |
| mask | output | 4 | Per-channel request mask, 1 = masked |
| mclr_pulse | output | 1 | One-cycle master-clear pulse |

## Verification
The bench reads all four mode registers and then a fifth time, to expose a counter that saturates or skips instead of wrapping. It clears the counter partway through a walk, to catch a clear that only takes effect a read late.

It sends the byte-pointer and mask-clear commands with all-ones and all-zeros data. A decoder that lets the data bus steer these commands would then leave a visibly wrong pointer or mask.

Single-channel mask writes are interleaved with clears of other channels, which would reveal a read-modify-write that disturbs neighbouring bits. Accesses with chip select low, or with both strobes high, are followed by a mode read that proves the pointer did not move.

Master clear is checked both for its state effects and for a pulse that lasts exactly one cycle.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

   localparam int ADDR_W = 4;

   // address map: channel registers below CHREG_LIM, commands above
   localparam logic [ADDR_W-1:0] A_MASK_ONE = 4'hA;
   localparam logic [ADDR_W-1:0] A_BYTE_PTR = 4'hC;
   localparam logic [ADDR_W-1:0] A_MCLR     = 4'hD;
   localparam logic [ADDR_W-1:0] A_MASK_CLR = 4'hE;
   localparam logic [ADDR_W-1:0] A_MASK_ALL = 4'hF;

   typedef struct packed {
      logic ptr_tgl;
      logic ptr_set;
      logic ptr_clr;
      logic mask_clr;
      logic mask_all;
      logic mask_one;
      logic mode_adv;
      logic mode_clr;
      logic mclr;
   } cmd_t;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
   import dma_cmd_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output cmd_t              cmd
);

   localparam logic [ADDR_W-1:0] CHREG_LIM = ADDR_W'(2 * NUM_CH);

   logic rd_acc, wr_acc;

   always_comb begin
      rd_acc = cs & rd & ~wr;
      wr_acc = cs & wr & ~rd;
      cmd    = '0;
      if ((rd_acc | wr_acc) && (addr < CHREG_LIM)) cmd.ptr_tgl = 1'b1;
      if (wr_acc) begin
         cmd.ptr_clr  = (addr == A_BYTE_PTR);
         cmd.mclr     = (addr == A_MCLR);
         cmd.mask_clr = (addr == A_MASK_CLR);
         cmd.mask_all = (addr == A_MASK_ALL);
         cmd.mask_one = (addr == A_MASK_ONE);
      end
      if (rd_acc) begin
         cmd.ptr_set  = (addr == A_BYTE_PTR);
         cmd.mode_clr = (addr == A_MCLR);
         cmd.mode_adv = (addr == A_MASK_ALL);
      end
   end

endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic mclr_i,
   input  logic clr_i,
   input  logic set_i,
   input  logic tgl_i,
   output logic hi_o
);

   logic hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hi_q <= 1'b0;
      else if (mclr_i || clr_i)  hi_q <= 1'b0;
      else if (set_i)            hi_q <= 1'b1;
      else if (tgl_i)            hi_q <= ~hi_q;
   end

   assign hi_o = hi_q;

   // R3
   byte_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgl_i && !mclr_i |=> hi_q != $past(hi_q));
   // R4
   byte_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> hi_q);
   // R4
   byte_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !hi_q);

endmodule

// File: rtl/dma_mode_rdptr.sv
module dma_mode_rdptr #(
   parameter int NUM_CH   = 4,
   parameter bit PTR_WRAP = 1'b1,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            adv_i,
   output logic [CH_W-1:0] ptr_o
);

   localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

   logic [CH_W-1:0] ptr_q, ptr_nx;

   generate
      if (PTR_WRAP) begin : g_wrap
         always_comb ptr_nx = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
         // R8
         mode_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            adv_i && !clr_i && ptr_q == LAST |=> ptr_q == '0);
      end else begin : g_sat
         always_comb ptr_nx = (ptr_q == LAST) ? LAST : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (clr_i)  ptr_q <= '0;
      else if (adv_i)  ptr_q <= ptr_nx;
   end

   assign ptr_o = ptr_q;

   // R9
   mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> ptr_q == '0);
   // R8
   mode_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !clr_i && ptr_q != LAST |=> ptr_q == CH_W'($past(ptr_q) + 1'b1));

endmodule

// File: rtl/dma_mask_reg.sv
module dma_mask_reg #(
   parameter int NUM_CH = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mclr_i,
   input  logic              clr_i,
   input  logic              all_i,
   input  logic [NUM_CH-1:0] all_val_i,
   input  logic              one_i,
   input  logic [CH_W-1:0]   one_sel_i,
   input  logic              one_val_i,
   output logic [NUM_CH-1:0] mask_o
);

   logic [NUM_CH-1:0] mask_q;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     mask_q[c] <= 1'b1;
            else if (mclr_i)                                mask_q[c] <= 1'b1;
            else if (clr_i)                                 mask_q[c] <= 1'b0;
            else if (all_i)                                 mask_q[c] <= all_val_i[c];
            else if (one_i && one_sel_i == CH_W'(c))        mask_q[c] <= one_val_i;
         end
      end
   endgenerate

   assign mask_o = mask_q;

   // R10
   mask_mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_i |=> &mask_q);
   // R5
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !mclr_i |=> mask_q == '0);
   // R7
   mask_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      one_i && !mclr_i && !clr_i && !all_i |=> $countones(mask_q ^ $past(mask_q)) <= 1);

endmodule

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl
   import dma_cmd_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int MODE_W   = 6,
   parameter int DATA_W   = 8,
   parameter bit PTR_WRAP = 1'b1,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs,
   input  logic                     rd,
   input  logic                     wr,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_CH*MODE_W-1:0] mode_bits,
   output logic [DATA_W-1:0]        rdata,
   output logic                     byte_hi,
   output logic [NUM_CH-1:0]        mask,
   output logic                     mclr_pulse
);

   generate
      if (NUM_CH != 2 && NUM_CH != 4) begin : g_bad_ch
         $error("dma_cmd_ctrl: NUM_CH must be 2 or 4");
      end
      if (DATA_W != MODE_W + 2) begin : g_bad_w
         $error("dma_cmd_ctrl: DATA_W must equal MODE_W + 2");
      end
   endgenerate

   cmd_t            cmd;
   logic [CH_W-1:0] mode_ptr;
   logic [MODE_W-1:0] mode_sel;
   logic            mclr_q;

   dma_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .cs   (cs),
      .rd   (rd),
      .wr   (wr),
      .addr (addr),
      .cmd  (cmd)
   );

   dma_byte_ptr u_bptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .mclr_i (cmd.mclr),
      .clr_i  (cmd.ptr_clr),
      .set_i  (cmd.ptr_set),
      .tgl_i  (cmd.ptr_tgl),
      .hi_o   (byte_hi)
   );

   dma_mode_rdptr #(.NUM_CH(NUM_CH), .PTR_WRAP(PTR_WRAP)) u_mptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cmd.mode_clr | cmd.mclr),
      .adv_i (cmd.mode_adv),
      .ptr_o (mode_ptr)
   );

   dma_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .mclr_i    (cmd.mclr),
      .clr_i     (cmd.mask_clr),
      .all_i     (cmd.mask_all),
      .all_val_i (wdata[NUM_CH-1:0]),
      .one_i     (cmd.mask_one),
      .one_sel_i (wdata[CH_W-1:0]),
      .one_val_i (wdata[CH_W]),
      .mask_o    (mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mclr_q <= 1'b0;
      else        mclr_q <= cmd.mclr;
   end

   assign mclr_pulse = mclr_q;
   assign mode_sel   = mode_bits[mode_ptr*MODE_W +: MODE_W];
   assign rdata      = cmd.mode_adv ? {mode_sel, 2'b11} : '0;

   // R10
   mclr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_pulse && !(cs && wr && !rd && addr == A_MCLR) |=> !mclr_pulse);
   // R10
   mclr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mclr_pulse) |-> &mask && !byte_hi);
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> $stable(mask) && $stable(byte_hi) && $stable(mode_ptr));
   // R11
   rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && rd) |-> rdata == '0);

endmodule

// File: tb/tb_dma_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_dma_cmd_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs, rd, wr;
   logic [3:0]  addr;
   logic [7:0]  wdata;
   logic [23:0] mode_bits;
   logic [7:0]  rdata;
   logic        byte_hi;
   logic [3:0]  mask;
   logic        mclr_pulse;

   int n_chk  = 0;
   int n_err  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dma_cmd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wdata(wdata), .mode_bits(mode_bits), .rdata(rdata),
      .byte_hi(byte_hi), .mask(mask), .mclr_pulse(mclr_pulse)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       cs, rd, wr;
      logic [3:0] addr;
      logic [7:0] wd;
      logic [7:0] exp_rd;
      logic [3:0] exp_mask;
      logic       exp_hi;
   } vec_t;

   // mode values: ch0 6'h01, ch1 6'h12, ch2 6'h23, ch3 6'h34
   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{4'd5,  1'b1,1'b0,1'b1, 4'hE, 8'h00, 8'h00, 4'h0, 1'b0}, // R5 clear mask
      '{4'd3,  1'b1,1'b0,1'b1, 4'h0, 8'hAA, 8'h00, 4'h0, 1'b1}, // R3 write chan reg
      '{4'd3,  1'b1,1'b1,1'b0, 4'h1, 8'h00, 8'h00, 4'h0, 1'b0}, // R3 R11 read chan reg
      '{4'd4,  1'b1,1'b1,1'b0, 4'hC, 8'h00, 8'h00, 4'h0, 1'b1}, // R4 set pointer
      '{4'd4,  1'b1,1'b0,1'b1, 4'hC, 8'hFF, 8'h00, 4'h0, 1'b0}, // R4 clear, data ignored
      '{4'd8,  1'b1,1'b1,1'b0, 4'hF, 8'h00, 8'h07, 4'h0, 1'b0}, // R8 ch0
      '{4'd8,  1'b1,1'b1,1'b0, 4'hF, 8'h00, 8'h4B, 4'h0, 1'b0}, // R8 ch1
      '{4'd9,  1'b1,1'b1,1'b0, 4'hD, 8'h00, 8'h00, 4'h0, 1'b0}, // R9 clear counter
      '{4'd9,  1'b1,1'b1,1'b0, 4'hF, 8'h00, 8'h07, 4'h0, 1'b0}, // R9 back at ch0
      '{4'd8,  1'b1,1'b1,1'b0, 4'hF, 8'h00, 8'h4B, 4'h0, 1'b0},
      '{4'd8,  1'b1,1'b1,1'b0, 4'hF, 8'h00, 8'h8F, 4'h0, 1'b0},
      '{4'd8,  1'b1,1'b1,1'b0, 4'hF, 8'h00, 8'hD3, 4'h0, 1'b0},
      '{4'd8,  1'b1,1'b1,1'b0, 4'hF, 8'h00, 8'h07, 4'h0, 1'b0}, // R8 wrap
      '{4'd7,  1'b1,1'b0,1'b1, 4'hA, 8'h06, 8'h00, 4'h4, 1'b0}, // R7 set ch2
      '{4'd7,  1'b1,1'b0,1'b1, 4'hA, 8'h01, 8'h00, 4'h4, 1'b0}, // R7 clear ch1
      '{4'd7,  1'b1,1'b0,1'b1, 4'hA, 8'h05, 8'h00, 4'h6, 1'b0}, // R7 set ch1
      '{4'd6,  1'b1,1'b0,1'b1, 4'hF, 8'h09, 8'h00, 4'h9, 1'b0}, // R6 load all
      '{4'd7,  1'b1,1'b0,1'b1, 4'hA, 8'h03, 8'h00, 4'h1, 1'b0}, // R7 clear ch3
      '{4'd3,  1'b1,1'b0,1'b1, 4'h7, 8'h00, 8'h00, 4'h1, 1'b1}, // R3 top chan reg
      '{4'd5,  1'b1,1'b0,1'b1, 4'hE, 8'hFF, 8'h00, 4'h0, 1'b1}, // R5 data ignored
      '{4'd2,  1'b0,1'b0,1'b1, 4'hC, 8'h00, 8'h00, 4'h0, 1'b1}, // R2 cs low
      '{4'd2,  1'b0,1'b1,1'b0, 4'hF, 8'h00, 8'h00, 4'h0, 1'b1}, // R2 cs low read
      '{4'd2,  1'b1,1'b1,1'b1, 4'hC, 8'h00, 8'h00, 4'h0, 1'b1}  // R2 both strobes
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic access(input logic c, input logic r, input logic w,
                         input logic [3:0] a, input logic [7:0] d,
                         output logic [7:0] seen);
      @(negedge clk);
      cs = c; rd = r; wr = w; addr = a; wdata = d;
      #1 seen = rdata;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      logic [7:0] seen;
      cs = 0; rd = 0; wr = 0; addr = '0; wdata = '0;
      mode_bits = {6'h34, 6'h23, 6'h12, 6'h01};
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mask",  mask, 4'hF);
      chk("R1 byte_hi", byte_hi, 1'b0);
      chk("R1 mclr_pulse", mclr_pulse, 1'b0);
      chk("R1 rdata", rdata, 8'h00);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i].cs, VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].wd, seen);
         chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), seen, VEC[i].exp_rd);
         chk($sformatf("R%0d vec%0d mask", VEC[i].req, i), mask, VEC[i].exp_mask);
         chk($sformatf("R%0d vec%0d byte_hi", VEC[i].req, i), byte_hi, VEC[i].exp_hi);
      end

      // R2: the ignored reads left the mode pointer at channel 1
      access(1'b1, 1'b1, 1'b0, 4'hF, 8'h00, seen);
      chk("R2 mode ptr held", seen, 8'h4B);

      // R10 master clear with data ignored
      access(1'b1, 1'b0, 1'b1, 4'hD, 8'h00, seen);
      chk("R10 mask set", mask, 4'hF);
      chk("R10 byte_hi cleared", byte_hi, 1'b0);
      chk("R10 pulse high", mclr_pulse, 1'b1);
      @(negedge clk);
      chk("R10 pulse one cycle", mclr_pulse, 1'b0);
      access(1'b1, 1'b1, 1'b0, 4'hF, 8'h00, seen);
      chk("R10 mode ptr cleared", seen, 8'h07);

      // R1 hardware reset mid-run
      access(1'b1, 1'b0, 1'b1, 4'hE, 8'h00, seen);
      access(1'b1, 1'b0, 1'b1, 4'h2, 8'h00, seen);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mask after reset", mask, 4'hF);
      chk("R1 byte_hi after reset", byte_hi, 1'b0);
      access(1'b1, 1'b1, 1'b0, 4'hF, 8'h00, seen);
      chk("R1 mode ptr after reset", seen, 8'h07);

      summary();
   end

endmodule